// File: doc/BRIEF.md
# Hibernation Power Sequencing Controller

This block decides when a chip leaves normal operation for a low-power hibernate state and when it comes back. It runs from the always-on slow clock. There are two ways in. Software can set a request bit. The block also goes in by itself when the main supply is lost while the battery is still valid. While the chip is hibernating, the block raises an active-low regulator enable, so the external regulator switches main power off. When an enabled wake source fires, the block lowers that output again, so the regulator turns main power back on.

There are three wake sources, and each has its own enable: a rising edge on the external wake pin, a match pulse from the real-time counter, and a low-battery flag. A separate option turns the low-battery flag into a veto that refuses a software request. The block keeps a sticky record of which source caused the last wake. Software clears that record with write-one-to-clear strobes. The rest of the chip is held in reset for the whole time it is hibernating and waking. That reset is released only after the wake delay has elapsed and main power has been reported good.

Top module: `hib_seq_ctrl`

## Requirements
- R1: After reset, the state code is ACTIVE, and `reg_off` is 0, `core_rst_n` is 1, and the request, deny and cause outputs are all 0. The state codes are ACTIVE=0, ENTERING=1, HIBERNATE=2 and WAKING=3.
- R2: A pulse on `sw_req_wr` sets `req_o` at the next edge. In ACTIVE, a set request moves the state to ENTERING at the following edge and clears `req_o`. ENTERING lasts `enter_cycles`+1 cycles and then gives way to HIBERNATE.
- R3: `reg_off` is 1 in exactly those cycles in which the state code is HIBERNATE.
- R4: In ACTIVE, `main_ok`=0 together with `batt_ok`=1 moves the state to ENTERING at the next edge. `main_ok`=0 together with `batt_ok`=0 leaves the state ACTIVE.
- R5: When `lowbat_block_en`=1 and `batt_low`=1, a request is consumed without any state change and `deny_o` becomes 1. A later request that is accepted clears `deny_o` to 0.
- R6: A 0-to-1 change on `wake_pin` passes through two synchronizing flops. In HIBERNATE with `pin_wake_en`=1, it moves the state to WAKING three edges after the change and sets cause bit 0. A pin that is already high, or a pin edge while the enable is 0, has no effect.
- R7: An `rtc_match` pulse in HIBERNATE with `rtc_wake_en`=1 moves the state to WAKING at the next edge and sets cause bit 1. With the enable at 0, the pulse is ignored.
- R8: `batt_low`=1 in HIBERNATE with `lowbat_wake_en`=1 moves the state to WAKING at the next edge and sets cause bit 2.
- R9: WAKING lasts at least `wake_cycles`+1 cycles, and it stays WAKING for as long as `main_ok` is 0. `core_rst_n` is 0 in exactly those cycles in which the state code is HIBERNATE or WAKING.
- R10: While any cause bit is 1, a request made in ACTIVE is consumed with no state change.
- R11: Cause bits are set only while the state code is HIBERNATE. A `cause_clr_wr` pulse clears the bits that are 1 in `cause_clr_mask`, one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_req_wr | input | 1 | Software write strobe that sets the hibernate request bit |
| main_ok | input | 1 | Main supply valid |
| batt_ok | input | 1 | Battery supply valid |
| batt_low | input | 1 | Battery below threshold |
| wake_pin | input | 1 | External wake pin, asynchronous |
| rtc_match | input | 1 | Real-time counter match pulse |
| pin_wake_en | input | 1 | Enables wake on a pin rising edge |
| rtc_wake_en | input | 1 | Enables wake on an RTC match |
| lowbat_wake_en | input | 1 | Enables wake on low battery |
| lowbat_block_en | input | 1 | Enables refusal of requests on low battery |
| enter_cycles | input | CNT_W | Extra cycles spent in ENTERING |
| wake_cycles | input | CNT_W | Extra cycles spent in WAKING |
| cause_clr_wr | input | 1 | Write-one-to-clear strobe for the cause bits |
| cause_clr_mask | input | 3 | Cause bits to clear |
| reg_off | output | 1 | Active-low regulator enable; 1 turns main power off |
| core_rst_n | output | 1 | Reset for the rest of the chip, active low |
| state_o | output | 2 | Current state code |
| req_o | output | 1 | Pending request bit |
| deny_o | output | 1 | Last request refused for low battery |
| cause_o | output | 3 | Sticky wake cause: bit0 pin, bit1 RTC, bit2 low battery |

## Verification
A wrong internal state shows up at the ports in the same cycle, because `reg_off`, `core_rst_n` and `state_o` all come from registered state. A state that is off by one shows up as a regulator or reset edge one cycle early or late, and the bench samples the exact edge count of every phase. A wrong synchronizer depth or a pin detector that reacts to the level shows up as a wake that arrives one edge early, or as a spurious wake while the pin is already high. A cause register that sets outside HIBERNATE first becomes visible when the next request is refused.

// File: rtl/hib_seq_pkg.sv
package hib_seq_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE    = 2'd0,
        ST_ENTERING  = 2'd1,
        ST_HIBERNATE = 2'd2,
        ST_WAKING    = 2'd3
    } hib_state_e;

    localparam int unsigned CAUSE_W   = 3;
    localparam int unsigned CAUSE_PIN = 0;
    localparam int unsigned CAUSE_RTC = 1;
    localparam int unsigned CAUSE_LOB = 2;

    typedef struct packed {
        hib_state_e state;
        logic       req;
        logic       deny;
        logic       reg_off;
        logic       core_rst_n;
    } hib_ctrl_t;

endpackage

// File: rtl/hib_wake_sync.sv
module hib_wake_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int unsigned TOT = STAGES + 1;

    logic [TOT-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[TOT-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/hib_phase_timer.sv
module hib_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                        cnt_d = load_val_i;
        else if (run_i && (cnt_q != '0))   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/hib_cause_reg.sv
module hib_cause_reg #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] cause_o
);
    logic [W-1:0] cause_d, cause_q;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (set_i[i])                        cause_d[i] = 1'b1;
            else if (clr_wr_i && clr_mask_i[i])  cause_d[i] = 1'b0;
            else                                 cause_d[i] = cause_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/hib_seq_ctrl.sv
module hib_seq_ctrl
    import hib_seq_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_req_wr,
    input  logic             main_ok,
    input  logic             batt_ok,
    input  logic             batt_low,
    input  logic             wake_pin,
    input  logic             rtc_match,
    input  logic             pin_wake_en,
    input  logic             rtc_wake_en,
    input  logic             lowbat_wake_en,
    input  logic             lowbat_block_en,
    input  logic [CNT_W-1:0] enter_cycles,
    input  logic [CNT_W-1:0] wake_cycles,
    input  logic             cause_clr_wr,
    input  logic [2:0]       cause_clr_mask,
    output logic             reg_off,
    output logic             core_rst_n,
    output logic [1:0]       state_o,
    output logic             req_o,
    output logic             deny_o,
    output logic [2:0]       cause_o
);
    localparam hib_ctrl_t RST_VAL = '{state: ST_ACTIVE, req: 1'b0, deny: 1'b0,
                                      reg_off: 1'b0, core_rst_n: 1'b1};

    hib_ctrl_t ctl_d, ctl_q;

    logic               pin_rise;
    logic               tmr_load, tmr_run, tmr_zero;
    logic [CNT_W-1:0]   tmr_val;
    logic [CAUSE_W-1:0] wake_set, cause_q;
    logic               any_wake, pending, lowbat_veto, power_lost;

    hib_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (wake_pin),
        .rise_o (pin_rise)
    );

    hib_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (tmr_run),
        .zero_o     (tmr_zero)
    );

    hib_cause_reg #(.W(CAUSE_W)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (wake_set),
        .clr_wr_i   (cause_clr_wr),
        .clr_mask_i (cause_clr_mask),
        .cause_o    (cause_q)
    );

    always_comb begin
        wake_set            = '0;
        wake_set[CAUSE_PIN] = pin_rise & pin_wake_en;
        wake_set[CAUSE_RTC] = rtc_match & rtc_wake_en;
        wake_set[CAUSE_LOB] = batt_low & lowbat_wake_en;
        if (ctl_q.state != ST_HIBERNATE) wake_set = '0;
        any_wake    = |wake_set;
        pending     = |cause_q;
        lowbat_veto = lowbat_block_en & batt_low;
        power_lost  = ~main_ok & batt_ok;
    end

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = enter_cycles;
        tmr_run  = 1'b0;
        unique case (ctl_q.state)
            ST_ACTIVE: begin
                ctl_d.req = ctl_q.req | sw_req_wr;
                if (power_lost) begin
                    ctl_d.state = ST_ENTERING;
                    ctl_d.req   = 1'b0;
                    tmr_load    = 1'b1;
                end else if (ctl_q.req) begin
                    ctl_d.req = sw_req_wr;
                    if (lowbat_veto) begin
                        ctl_d.deny = 1'b1;
                    end else if (!pending) begin
                        ctl_d.state = ST_ENTERING;
                        ctl_d.deny  = 1'b0;
                        ctl_d.req   = 1'b0;
                        tmr_load    = 1'b1;
                    end
                end
            end
            ST_ENTERING: begin
                ctl_d.req = 1'b0;
                tmr_run   = 1'b1;
                if (tmr_zero) ctl_d.state = ST_HIBERNATE;
            end
            ST_HIBERNATE: begin
                ctl_d.req = 1'b0;
                if (any_wake) begin
                    ctl_d.state = ST_WAKING;
                    tmr_load    = 1'b1;
                    tmr_val     = wake_cycles;
                end
            end
            ST_WAKING: begin
                ctl_d.req = 1'b0;
                tmr_run   = 1'b1;
                if (tmr_zero && main_ok) ctl_d.state = ST_ACTIVE;
            end
            default: ctl_d.state = ST_ACTIVE;
        endcase
        ctl_d.reg_off    = (ctl_d.state == ST_HIBERNATE);
        ctl_d.core_rst_n = ~((ctl_d.state == ST_HIBERNATE) || (ctl_d.state == ST_WAKING));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= RST_VAL;
        else        ctl_q <= ctl_d;
    end

    assign reg_off    = ctl_q.reg_off;
    assign core_rst_n = ctl_q.core_rst_n;
    assign state_o    = ctl_q.state;
    assign req_o      = ctl_q.req;
    assign deny_o     = ctl_q.deny;
    assign cause_o    = cause_q;
endmodule

// File: rtl/hib_seq_checker.sv
module hib_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       main_ok,
    input logic       batt_low,
    input logic       lowbat_block_en,
    input logic       reg_off,
    input logic       core_rst_n,
    input logic [1:0] state_o,
    input logic       req_o,
    input logic [2:0] cause_o
);
    localparam logic [1:0] S_ACT = 2'd0;
    localparam logic [1:0] S_HIB = 2'd2;
    localparam logic [1:0] S_WAK = 2'd3;

    assert_regoff_only_hib_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_off == (state_o == S_HIB));

    assert_core_reset_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n == !((state_o == S_HIB) || (state_o == S_WAK)));

    assert_waking_waits_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_WAK && !main_ok) |=> (state_o == S_WAK));

    assert_hib_exits_to_waking_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_HIB) |=> (state_o == S_HIB || state_o == S_WAK));

    assert_lowbat_veto_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_ACT && req_o && batt_low && lowbat_block_en && main_ok)
        |=> (state_o == S_ACT));

    assert_cause_sets_in_hib_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != S_HIB) |=> ((cause_o & ~$past(cause_o)) == 3'b000));
endmodule

bind hib_seq_ctrl hib_seq_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .main_ok         (main_ok),
    .batt_low        (batt_low),
    .lowbat_block_en (lowbat_block_en),
    .reg_off         (reg_off),
    .core_rst_n      (core_rst_n),
    .state_o         (state_o),
    .req_o           (req_o),
    .cause_o         (cause_o)
);

// File: tb/tb_hib_seq_ctrl.sv
`timescale 1ns/1ps
module tb_hib_seq_ctrl;
    localparam int CW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sw_req_wr = 0, main_ok = 1, batt_ok = 1, batt_low = 0;
    logic wake_pin = 0, rtc_match = 0;
    logic pin_wake_en = 0, rtc_wake_en = 0, lowbat_wake_en = 0, lowbat_block_en = 0;
    logic [CW-1:0] enter_cycles = 8'd3, wake_cycles = 8'd2;
    logic cause_clr_wr = 0;
    logic [2:0] cause_clr_mask = 3'b000;
    logic reg_off, core_rst_n, req_o, deny_o;
    logic [1:0] state_o;
    logic [2:0] cause_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hib_seq_ctrl #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .sw_req_wr(sw_req_wr), .main_ok(main_ok),
        .batt_ok(batt_ok), .batt_low(batt_low), .wake_pin(wake_pin),
        .rtc_match(rtc_match), .pin_wake_en(pin_wake_en), .rtc_wake_en(rtc_wake_en),
        .lowbat_wake_en(lowbat_wake_en), .lowbat_block_en(lowbat_block_en),
        .enter_cycles(enter_cycles), .wake_cycles(wake_cycles),
        .cause_clr_wr(cause_clr_wr), .cause_clr_mask(cause_clr_mask),
        .reg_off(reg_off), .core_rst_n(core_rst_n), .state_o(state_o),
        .req_o(req_o), .deny_o(deny_o), .cause_o(cause_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        sw_req_wr = 1; step(1); sw_req_wr = 0;
    endtask

    task automatic clear_cause(input logic [2:0] m);
        cause_clr_mask = m; cause_clr_wr = 1; step(1); cause_clr_wr = 0;
    endtask

    task automatic t_reset();
        check("R1 state", state_o, 0);
        check("R1 reg_off", reg_off, 0);
        check("R1 core_rst_n", core_rst_n, 1);
        check("R1 req/deny", {req_o, deny_o}, 0);
        check("R1 cause", cause_o, 0);
    endtask

    task automatic t_sw_entry();
        pulse_req();
        check("R2 req set", req_o, 1);
        check("R2 still active", state_o, 0);
        step(1);
        check("R2 entering", state_o, 1);
        check("R2 req self-clear", req_o, 0);
        check("R3 reg on while entering", reg_off, 0);
        step(3);
        check("R2 entering length", state_o, 1);
        step(1);
        check("R2 hibernate", state_o, 2);
        check("R3 reg_off in hib", reg_off, 1);
        check("R9 core reset in hib", core_rst_n, 0);
    endtask

    task automatic t_pin_wake();
        pin_wake_en = 1; wake_pin = 1;
        step(2);
        check("R6 sync delay", state_o, 2);
        step(1);
        check("R6 pin wake", state_o, 3);
        check("R6 cause pin", cause_o, 3'b001);
        check("R3 reg on while waking", reg_off, 0);
        step(2);
        check("R9 waking length", state_o, 3);
        check("R9 reset held waking", core_rst_n, 0);
        step(1);
        check("R9 active", state_o, 0);
        check("R9 core released", core_rst_n, 1);
    endtask

    task automatic t_pending();
        pulse_req();
        step(1);
        check("R10 pending ignores request", state_o, 0);
        check("R10 request consumed", req_o, 0);
        clear_cause(3'b001);
        check("R11 w1c clear", cause_o, 0);
    endtask

    task automatic t_lowbat_block();
        lowbat_block_en = 1; batt_low = 1;
        pulse_req();
        step(1);
        check("R5 refused", state_o, 0);
        check("R5 deny set", deny_o, 1);
        batt_low = 0;
    endtask

    task automatic t_main_loss();
        main_ok = 0; batt_ok = 0;
        step(3);
        check("R4 no battery stays active", state_o, 0);
        batt_ok = 1;
        step(1);
        check("R4 power loss entering", state_o, 1);
        step(3);
        check("R4 entering length", state_o, 1);
        step(1);
        check("R4 hibernate", state_o, 2);
    endtask

    task automatic t_rtc_wake();
        rtc_wake_en = 0; rtc_match = 1; step(1); rtc_match = 0;
        step(1);
        check("R7 disabled rtc ignored", state_o, 2);
        check("R7 disabled no cause", cause_o, 0);
        rtc_wake_en = 1; rtc_match = 1; step(1); rtc_match = 0;
        check("R7 rtc wake", state_o, 3);
        check("R7 cause rtc", cause_o, 3'b010);
        step(5);
        check("R9 waits for main_ok", state_o, 3);
        main_ok = 1;
        step(1);
        check("R9 active after power", state_o, 0);
        rtc_wake_en = 0;
    endtask

    task automatic t_lowbat_wake();
        clear_cause(3'b111);
        pulse_req();
        step(1);
        check("R5 accepted entry", state_o, 1);
        check("R5 deny cleared", deny_o, 0);
        step(4);
        check("R8 in hib", state_o, 2);
        lowbat_wake_en = 1; batt_low = 1;
        step(1);
        check("R8 lowbat wake", state_o, 3);
        check("R8 cause lowbat", cause_o, 3'b100);
        step(3);
        check("R8 back active", state_o, 0);
        batt_low = 0; lowbat_wake_en = 0;
    endtask

    task automatic t_zero_delay_edge();
        clear_cause(3'b111);
        enter_cycles = 0; wake_pin = 0; pin_wake_en = 0;
        pulse_req();
        step(1);
        check("R2 zero delay entering", state_o, 1);
        step(1);
        check("R2 zero delay hib", state_o, 2);
        wake_pin = 1;
        step(4);
        check("R6 disabled edge ignored", state_o, 2);
        pin_wake_en = 1;
        step(2);
        check("R6 high level ignored", state_o, 2);
        check("R11 no cause from level", cause_o, 0);
        wake_pin = 0; step(2); wake_pin = 1;
        step(3);
        check("R6 new edge wakes", state_o, 3);
        check("R6 cause pin again", cause_o, 3'b001);
    endtask

    initial begin
        step(2);
        rst_n = 1;
        step(1);
        t_reset();
        t_sw_entry();
        t_pin_wake();
        t_pending();
        t_lowbat_block();
        t_main_loss();
        t_rtc_wake();
        t_lowbat_wake();
        t_zero_delay_edge();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule